// File: doc/BRIEF.md
# Vectorised int16 / bfloat16 Converter

This block converts a stream of vectors between 16-bit two's-complement integers and bfloat16 values. A compile-time parameter fixes the direction of an instance. Every clock cycle the block can take one vector of `LANES` independent 16-bit lanes. Each vector comes out converted two cycles later. A valid flag travels with the data. There is no backpressure, so an upstream producer may present a new vector on every cycle.

The integer side is a fixed-point view of the float side with a power-of-two scale. The parameter `SCALE_EXP` holds the exponent of that scale. When an integer is turned into a float, the result is the integer times 2^-SCALE_EXP. This is done only by offsetting the float exponent, so no multiplier is needed. When a float is turned into an integer, the value is multiplied by 2^SCALE_EXP, floored, and saturated to the int16 range.

Top module: `vec_i16bf16_conv`

## Requirements
- R1: `out_vld` equals `in_vld` delayed by exactly two clock cycles. A vector taken in cycle t appears on `out_data` in cycle t+2, and back-to-back vectors come out back-to-back.
- R2: In the integer-to-float direction, each lane's result is x·2^-SCALE_EXP rounded to an 8-bit significand. The layout is bit 15 = sign, bits 14:7 = biased exponent (bias 127), and bits 6:0 = fraction.
- R3: Integer-to-float rounding is round-to-nearest with ties going to an even fraction. A round-up that overflows the significand increments the exponent.
- R4: Integer 0 converts to 0x0000. For non-zero inputs, the float sign bit equals the integer's two's-complement sign bit.
- R5: In the float-to-integer direction, a finite normal input v gives floor(v·2^SCALE_EXP) whenever that value lies in [-32768, 32767].
- R6: Float-to-integer results above 32767 give 0x7FFF, and results below -32768 give 0x8000. +Inf (0x7F80) gives 0x7FFF and -Inf (0xFF80) gives 0x8000.
- R7: A NaN input (exponent 0xFF with a non-zero fraction) gives 0 in the float-to-integer direction.
- R8: A normal float whose scaled magnitude is below 1 gives 0 when positive and 0xFFFF (-1) when negative. Zero and subnormal inputs (exponent 0), of either sign, give 0.
- R9: Lane i occupies bits [16i+15:16i] of both buses. Each lane is converted independently of the others in the same vector.
- R10: While `rst_n` is low at a clock edge, `out_vld` and `out_data` are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | Input vector is valid this cycle |
| in_data | input | 16*LANES | Input vector, lane i at bits [16i+15:16i] |
| out_vld | output | 1 | Output vector is valid this cycle |
| out_data | output | 16*LANES | Converted vector, same lane layout |

## Verification
Each lane holds only two registers of state, so a corrupted stage shows up as a wrong word in one lane two cycles after the input. A valid pipeline that drops, duplicates or shifts a flag is visible at once as a gap or an extra pulse on `out_vld` during back-to-back streaming. Errors in rounding or exponent arithmetic appear only for particular values: ties, significand carry-outs, saturation limits and sub-unity magnitudes. Those values are therefore driven explicitly, alongside a random sweep that is compared against a model built on real-number arithmetic.

// File: rtl/vec_cvt_pkg.sv
// Package: shared word type and a leading-zero count for 16-bit magnitudes.
// Assumes: callers pass values of exactly 16 bits.
package vec_cvt_pkg;

    localparam int WORD_W = 16;

    typedef logic [WORD_W-1:0] word_t;

    // Count of zero bits above the highest set bit; 16 for an all-zero word.
    function automatic logic [4:0] lead_zeros(input word_t v);
        lead_zeros = 5'd16;
        for (int b = 0; b < WORD_W; b++) begin
            if (v[b]) lead_zeros = 5'(WORD_W - 1 - b);
        end
    endfunction

endpackage

// File: rtl/i2bf_lane.sv
// Lane converting a signed 16-bit integer to bfloat16 scaled by 2^-SCALE_EXP.
// Two register stages: input capture, then the rounded result.
// Assumes: SCALE_EXP keeps every exponent in 1..254 (checked in the top).
module i2bf_lane
    import vec_cvt_pkg::*;
#(
    parameter int SCALE_EXP = 12
) (
    input  logic  clk,
    input  logic  rst_n,
    input  word_t d_i,
    output word_t q_o
);

    word_t               x_q;
    word_t               y_q;
    word_t               mag;
    word_t               norm;
    logic [4:0]          lz;
    logic                rnd_up;
    logic [8:0]          sig9;
    logic signed [9:0]   exp_w;
    word_t               y_d;

    // Capture the lane input word.
    always_ff @(posedge clk) begin
        if (!rst_n) x_q <= '0;
        else        x_q <= d_i;
    end

    // Normalise, round to nearest even, and build the float fields.
    always_comb begin
        mag    = x_q[15] ? (~x_q + 16'd1) : x_q;
        lz     = lead_zeros(mag);
        norm   = mag << lz[3:0];
        rnd_up = norm[7] & ((|norm[6:0]) | norm[8]);
        sig9   = {1'b0, norm[15:8]} + {8'd0, rnd_up};
        exp_w  = 10'sd142 - $signed({5'd0, lz}) - 10'(SCALE_EXP)
                 + $signed({9'd0, sig9[8]});
        if (mag == '0) y_d = '0;
        else           y_d = {x_q[15], exp_w[7:0], (sig9[8] ? 7'd0 : sig9[6:0])};
    end

    // Register the converted word.
    always_ff @(posedge clk) begin
        if (!rst_n) y_q <= '0;
        else        y_q <= y_d;
    end

    assign q_o = y_q;

    AST_ZERO_IN_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (x_q == '0) |=> (y_q == '0)); // R4
    AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (x_q != '0) |=> (y_q[15] == $past(x_q[15]))); // R4
    AST_EXP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (x_q != '0) |-> (exp_w > 10'sd0 && exp_w < 10'sd255)); // R2
    AST_HIDDEN_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (x_q != '0) |-> (sig9[8] | sig9[7])); // R3

endmodule

// File: rtl/bf2i_lane.sv
// Lane converting bfloat16 to a signed 16-bit integer: floor(v * 2^SCALE_EXP),
// saturated. NaN gives 0, zero and subnormals give 0.
// Two register stages: input capture, then the result.
module bf2i_lane
    import vec_cvt_pkg::*;
#(
    parameter int SCALE_EXP = 12
) (
    input  logic  clk,
    input  logic  rst_n,
    input  word_t d_i,
    output word_t q_o
);

    localparam word_t POS_MAX = 16'h7FFF;
    localparam word_t NEG_MAX = 16'h8000;

    word_t             a_q;
    word_t             y_q;
    logic              sgn;
    logic [7:0]        bexp;
    logic [6:0]        frac;
    logic signed [9:0] k;
    logic [22:0]       wide;
    word_t             ip;
    logic              frac_nz;
    word_t             y_d;

    // Capture the lane input word.
    always_ff @(posedge clk) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= d_i;
    end

    // Decode fields, align the significand, and apply floor and saturation.
    always_comb begin
        sgn     = a_q[15];
        bexp    = a_q[14:7];
        frac    = a_q[6:0];
        k       = $signed({2'b00, bexp}) - 10'sd127 + 10'(SCALE_EXP);
        wide    = {15'd0, 1'b1, frac} << k[3:0];
        ip      = wide[22:7];
        frac_nz = |wide[6:0];
        if (bexp == 8'hFF)        y_d = (frac != '0) ? '0 : (sgn ? NEG_MAX : POS_MAX);
        else if (bexp == 8'h00)   y_d = '0;
        else if (k < 10'sd0)      y_d = sgn ? 16'hFFFF : '0;
        else if (k > 10'sd14)     y_d = sgn ? NEG_MAX : POS_MAX;
        else if (sgn)             y_d = ~(ip + {15'd0, frac_nz}) + 16'd1;
        else                      y_d = ip;
    end

    // Register the converted word.
    always_ff @(posedge clk) begin
        if (!rst_n) y_q <= '0;
        else        y_q <= y_d;
    end

    assign q_o = y_q;

    AST_NAN_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (a_q[14:7] == 8'hFF && a_q[6:0] != '0) |=> (y_q == '0)); // R7
    AST_INF_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (a_q[14:0] == 15'h7F80) |=> (y_q == ($past(a_q[15]) ? NEG_MAX : POS_MAX))); // R6
    AST_DENORM_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (a_q[14:7] == 8'h00) |=> (y_q == '0)); // R8
    AST_POS_NOT_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        (a_q[15] == 1'b0) |=> (y_q[15] == 1'b0)); // R5

endmodule

// File: rtl/vec_i16bf16_conv.sv
// Top: LANES independent lanes converting in lockstep, direction fixed by
// TO_FLOAT (1: int16 -> bf16, 0: bf16 -> int16). Latency is two cycles.
// Assumes: no backpressure; SCALE_EXP in -111..126.
module vec_i16bf16_conv
    import vec_cvt_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int SCALE_EXP = 12,
    parameter bit TO_FLOAT  = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_vld,
    input  logic [WORD_W*LANES-1:0] in_data,
    output logic                    out_vld,
    output logic [WORD_W*LANES-1:0] out_data
);

    localparam int LAT = 2;

    logic [LAT-1:0] vld_pipe;
    logic [1:0]     since_rst;

    if (SCALE_EXP < -111 || SCALE_EXP > 126) begin : g_bad_scale
        $error("SCALE_EXP out of supported range");
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        if (TO_FLOAT) begin : g_i2bf
            i2bf_lane #(.SCALE_EXP(SCALE_EXP)) u_lane (
                .clk   (clk),
                .rst_n (rst_n),
                .d_i   (in_data[WORD_W*i +: WORD_W]),
                .q_o   (out_data[WORD_W*i +: WORD_W])
            );
        end else begin : g_bf2i
            bf2i_lane #(.SCALE_EXP(SCALE_EXP)) u_lane (
                .clk   (clk),
                .rst_n (rst_n),
                .d_i   (in_data[WORD_W*i +: WORD_W]),
                .q_o   (out_data[WORD_W*i +: WORD_W])
            );
        end
    end

    // Delay the valid flag alongside the lane registers.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_pipe <= '0;
        else        vld_pipe <= {vld_pipe[LAT-2:0], in_vld};
    end

    assign out_vld = vld_pipe[LAT-1];

    // Count cycles since reset so the latency check only looks at valid history.
    always_ff @(posedge clk) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst != 2) since_rst <= since_rst + 2'd1;
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2) |-> (out_vld == $past(in_vld, 2))); // R1
    AST_RESET_CLEARS: assert property (@(posedge clk)
        (!rst_n) |=> (!out_vld)); // R10

endmodule

// File: tb/test_vec_i16bf16_conv.sv
`timescale 1ns/1ps
module test_vec_i16bf16_conv;

    localparam int L  = 4;
    localparam int SC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_vld = 1'b0;
    logic [16*L-1:0] din_f = '0, din_i = '0;
    logic [16*L-1:0] dout_f, dout_i;
    logic          vld_f, vld_i;
    int            n_run = 0, n_fail = 0;
    bit            done = 1'b0;

    always #10 clk = ~clk;

    vec_i16bf16_conv #(.LANES(L), .SCALE_EXP(SC), .TO_FLOAT(1'b1)) i_vec_i16bf16_conv (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(din_f),
        .out_vld(vld_f), .out_data(dout_f));

    vec_i16bf16_conv #(.LANES(L), .SCALE_EXP(SC), .TO_FLOAT(1'b0)) i_vec_i16bf16_conv_rev (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(din_i),
        .out_vld(vld_i), .out_data(dout_i));

    // Reference: integer x to bfloat16 of x*2^-SC, round to nearest even.
    function automatic logic [15:0] ref_i2b(input logic [15:0] xw);
        int  x = int'($signed(xw));
        int  e = 0;
        real v, t, f, r;
        if (x == 0) return 16'h0000;
        v = ((x < 0) ? -x : x) / (2.0 ** SC);
        while (v >= 2.0) begin v = v / 2.0; e++; end
        while (v < 1.0)  begin v = v * 2.0; e--; end
        t = v * 128.0;
        f = $floor(t);
        r = t - f;
        if (r > 0.5 || (r == 0.5 && ($rtoi(f) % 2) == 1)) f = f + 1.0;
        if (f >= 256.0) begin f = 128.0; e++; end
        return {(x < 0), 8'(e + 127), 7'($rtoi(f) - 128)};
    endfunction

    // Reference: bfloat16 to floor(v*2^SC), saturated.
    function automatic logic [15:0] ref_b2i(input logic [15:0] b);
        int  e = int'(b[14:7]);
        real v, f;
        if (e == 255) return (b[6:0] != 0) ? 16'h0000 : (b[15] ? 16'h8000 : 16'h7FFF);
        if (e == 0) return 16'h0000;
        v = (1.0 + b[6:0] / 128.0) * (2.0 ** (e - 127 + SC));
        if (b[15]) v = -v;
        f = $floor(v);
        if (f > 32767.0)  return 16'h7FFF;
        if (f < -32768.0) return 16'h8000;
        return 16'($rtoi(f));
    endfunction

    function automatic logic [16*L-1:0] pk(input logic [15:0] a0, a1, a2, a3);
        return {a3, a2, a1, a0};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one vector into both instances and wait until its result is out.
    task automatic send(input logic [16*L-1:0] f_in, input logic [16*L-1:0] i_in);
        @(negedge clk);
        din_f = f_in; din_i = i_in; in_vld = 1'b1;
        @(negedge clk);
        in_vld = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 vld_f", {15'd0, vld_f}, 16'd0);
        chk("R10 vld_i", {15'd0, vld_i}, 16'd0);
        chk("R10 data_f", dout_f[15:0], 16'h0000);
        chk("R10 data_i", dout_i[63:48], 16'h0000);
        rst_n = 1'b1;
    endtask

    task automatic t_i2b_basic();
        send(pk(16'd16, 16'hFFF0, 16'd0, 16'd1), '0);
        chk("R2 16/16=1.0", dout_f[15:0], 16'h3F80);
        chk("R4 negative sign", dout_f[31:16], 16'hBF80);
        chk("R4 zero", dout_f[47:32], 16'h0000);
        chk("R2 smallest step", dout_f[63:48], 16'h3D80);
    endtask

    task automatic t_i2b_round();
        send(pk(16'd257, 16'd259, 16'd511, 16'h8000), '0);
        chk("R3 tie to even down", dout_f[15:0], 16'h4180);
        chk("R3 tie to even up", dout_f[31:16], 16'h4182);
        chk("R3 carry into exponent", dout_f[47:32], 16'h4200);
        chk("R2 most negative", dout_f[63:48], 16'hC500);
        send(pk(16'h7FFF, 16'hFEFF, 16'd0, 16'd0), '0);
        chk("R3 max rounds up", dout_f[15:0], 16'h4500);
        chk("R3 negative tie", dout_f[31:16], ref_i2b(16'hFEFF));
    endtask

    task automatic t_b2i_basic();
        send('0, pk(16'h3F80, 16'hBF80, 16'h3D80, 16'h3DC0));
        chk("R5 1.0", dout_i[15:0], 16'd16);
        chk("R5 -1.0", dout_i[31:16], 16'hFFF0);
        chk("R5 one step", dout_i[47:32], 16'd1);
        chk("R5 floor positive", dout_i[63:48], 16'd1);
        send('0, pk(16'hBDC0, 16'hC500, 16'h4480, 16'h0000));
        chk("R5 floor negative", dout_i[15:0], 16'hFFFE);
        chk("R5 exact minimum", dout_i[31:16], 16'h8000);
        chk("R5 1024*16", dout_i[47:32], 16'h4000);
    endtask

    task automatic t_b2i_sat();
        send('0, pk(16'h4700, 16'hC700, 16'h7F80, 16'hFF80));
        chk("R6 large positive", dout_i[15:0], 16'h7FFF);
        chk("R6 large negative", dout_i[31:16], 16'h8000);
        chk("R6 +Inf", dout_i[47:32], 16'h7FFF);
        chk("R6 -Inf", dout_i[63:48], 16'h8000);
        send('0, pk(16'h4500, 16'h7FC0, 16'hFFC1, 16'h0000));
        chk("R6 exactly 32768", dout_i[15:0], 16'h7FFF);
        chk("R7 NaN", dout_i[31:16], 16'h0000);
        chk("R7 negative NaN", dout_i[47:32], 16'h0000);
    endtask

    task automatic t_b2i_small();
        send('0, pk(16'h3D00, 16'hBD00, 16'h0001, 16'h8001));
        chk("R8 half positive", dout_i[15:0], 16'h0000);
        chk("R8 half negative", dout_i[31:16], 16'hFFFF);
        chk("R8 subnormal", dout_i[47:32], 16'h0000);
        chk("R8 negative subnormal", dout_i[63:48], 16'h0000);
        send('0, pk(16'h8000, 16'h0000, 16'h3F80, 16'h3F80));
        chk("R8 negative zero", dout_i[15:0], 16'h0000);
        chk("R8 zero", dout_i[31:16], 16'h0000);
    endtask

    // Back-to-back random vectors: latency, valid alignment, lane independence.
    task automatic t_stream(input int n);
        logic [16*L-1:0] ef [64];
        logic [16*L-1:0] ei [64];
        for (int c = 0; c < n + 2; c++) begin
            if (c >= 2) begin
                chk("R1 vld_f streaming", {15'd0, vld_f}, 16'd1);
                chk("R1 vld_i streaming", {15'd0, vld_i}, 16'd1);
                for (int i = 0; i < L; i++) begin
                    chk("R9 lane i2b", dout_f[16*i +: 16], ef[c-2][16*i +: 16]);
                    chk("R9 lane b2i", dout_i[16*i +: 16], ei[c-2][16*i +: 16]);
                end
            end
            if (c < n) begin
                for (int i = 0; i < L; i++) begin
                    din_f[16*i +: 16] = 16'($urandom);
                    din_i[16*i +: 16] = 16'($urandom);
                    ef[c][16*i +: 16] = ref_i2b(din_f[16*i +: 16]);
                    ei[c][16*i +: 16] = ref_b2i(din_i[16*i +: 16]);
                end
                in_vld = 1'b1;
            end else begin
                in_vld = 1'b0;
            end
            @(negedge clk);
        end
        chk("R1 vld_f falls", {15'd0, vld_f}, 16'd0);
        chk("R1 vld_i falls", {15'd0, vld_i}, 16'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_i2b_basic();
        t_i2b_round();
        t_b2i_basic();
        t_b2i_sat();
        t_b2i_small();
        for (int r = 0; r < 8; r++) t_stream(60);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule